// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a single-beat request interface using valid and ready to an external 32K x 8 asynchronous static RAM. A request is either a read or a write. The block takes it in one clock and then produces the active-low chip-enable, output-enable and write-enable strobes, the 15-bit address and the 8-bit write data for the memory. It drives the data bus through a separate output-enable line, which the pad-level tri-state buffer outside the block uses. A read returns its byte on a response port together with a one-clock valid pulse.

Every phase length is a whole number of system clocks. The counts come from parameters: the clock period and the memory's timing minima, all in nanoseconds. A read holds the chip enable and output enable low long enough to cover both the address access time and the output-enable access time, and it samples the bus on the last clock of that window. Both strobes then rise, and a turnaround window follows so that the memory's output drivers have released the bus before the next access. A write is controlled by write-enable. It drives the data bus for one setup clock, holds write-enable low for the pulse count, and keeps the address and data for one recovery clock. Output-enable stays high for the whole write, so only one side drives the bus at any time.

The states are IDLE, READ_WAIT, SAMPLE, TURNAROUND, WRITE_SETUP, WRITE_PULSE and WRITE_RECOVER. The transitions are:
- IDLE to READ_WAIT on a read request, and IDLE to WRITE_SETUP on a write request.
- READ_WAIT to SAMPLE when its count expires, then SAMPLE to TURNAROUND, then TURNAROUND to IDLE when its count expires.
- WRITE_SETUP to WRITE_PULSE, then WRITE_PULSE to WRITE_RECOVER when its count expires, then WRITE_RECOVER to IDLE.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held, and in the first clock after it, the memory strobes mem_ce_n, mem_oe_n and mem_we_n are all 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: req_ready is 1 only while the controller is idle. A request is taken on a clock edge where req_valid and req_ready are both 1, and req_write=1 selects a write. While the controller is busy, req_valid has no effect.
- R3: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for RD_CLKS+1 clocks, starting the clock after acceptance. It then holds all three strobes at 1 for TA_CLKS turnaround clocks, and req_ready returns to 1 on the following clock.
- R4: The read byte is mem_dq_i as sampled on the last clock of the read strobe window. It appears on rsp_rdata with rsp_valid=1 for exactly one clock, and that clock is the first turnaround clock.
- R5: A write holds mem_ce_n=0 for WR_CLKS+2 clocks, starting the clock after acceptance. mem_we_n is 1 for the first clock, 0 for the next WR_CLKS clocks and 1 for the last clock.
- R6: mem_oe_n stays 1 for the whole write. mem_dq_oe is 1 on exactly the WR_CLKS+2 clocks of a write and 0 at all other times, so the controller never drives the bus while mem_oe_n is 0.
- R7: mem_addr, and mem_dq_o during a write, keep the values of req_addr and req_wdata from the acceptance clock for the whole access, even if those host inputs change.
- R8: A phase count is ceil(time_ns / CLK_NS), and never less than 1. RD_CLKS is the larger of the address-access and output-enable-access counts. WR_CLKS is the largest of the pulse-width count, the data-setup count, and the cycle-time count minus 2. TA_CLKS is the count for the bus-release time.
- R9: Whenever mem_ce_n is 1 (standby), mem_oe_n and mem_we_n are 1 and mem_dq_oe is 0.
- R10: A write never produces an rsp_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address of the request |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-clock pulse marking read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 15 | Address to the memory |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_i | input | 8 | Data from the memory bus |
| mem_dq_oe | output | 1 | Enables the controller's bus driver |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The strobes and the bus enable are decoded straight from the state register, so a wrong state shows on mem_ce_n, mem_oe_n, mem_we_n or mem_dq_oe in the very next clock. A wrong phase counter has a different effect: it stretches or shortens one strobe window by whole clocks, and this appears on the first access of the affected kind. A sample taken in the wrong clock returns the memory model's idle pattern (0xEE) instead of the stored byte, and it does so on the first read. Address or data that is not held stable appears as a mismatch on mem_addr or mem_dq_o in the same clock as the change on the host inputs.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_WAIT,
        ST_SAMPLE,
        ST_TURNAROUND,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } sram_state_e;

    // Clocks needed to cover a duration, never fewer than one.
    function automatic int unsigned clk_count(input int unsigned dur_ns,
                                              input int unsigned per_ns);
        int unsigned c;
        c = (dur_ns + per_ns - 1) / per_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_req_hold.sv
module sram_req_hold #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (capture) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [DATA_W-1:0] bus_in,
    output logic              valid_q,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= sample;
            if (sample) begin
                data_q <= bus_in;
            end
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W          = 15,
    parameter int DATA_W          = 8,
    parameter int CLK_NS          = 4,
    parameter int T_ADDR_ACC_NS   = 10,
    parameter int T_OE_ACC_NS     = 5,
    parameter int T_WR_CYCLE_NS   = 10,
    parameter int T_WE_WIDTH_NS   = 8,
    parameter int T_DATA_SETUP_NS = 6,
    parameter int T_RELEASE_NS    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    // R8: phase lengths in clocks
    localparam int unsigned RD_CLKS = umax(clk_count(T_ADDR_ACC_NS, CLK_NS),
                                           clk_count(T_OE_ACC_NS, CLK_NS));
    localparam int unsigned WC_CLKS = clk_count(T_WR_CYCLE_NS, CLK_NS);
    localparam int unsigned WC_REST = (WC_CLKS > 2) ? WC_CLKS - 2 : 1;
    localparam int unsigned WR_CLKS = umax(umax(clk_count(T_WE_WIDTH_NS, CLK_NS),
                                                clk_count(T_DATA_SETUP_NS, CLK_NS)),
                                           WC_REST);
    localparam int unsigned TA_CLKS = clk_count(T_RELEASE_NS, CLK_NS);
    localparam int unsigned MAX_CLKS = umax(umax(RD_CLKS, WR_CLKS), TA_CLKS);
    localparam int CNT_W = (MAX_CLKS < 2) ? 1 : $clog2(MAX_CLKS);

    sram_state_e      st_q, st_d;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_done;
    logic             accept;
    logic             sample;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state and timer reload
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:       if (req_valid) st_d = req_write ? ST_WR_SETUP : ST_READ_WAIT;
            ST_READ_WAIT:  if (timer_done) st_d = ST_SAMPLE;
            ST_SAMPLE:     st_d = ST_TURNAROUND;
            ST_TURNAROUND: if (timer_done) st_d = ST_IDLE;
            ST_WR_SETUP:   st_d = ST_WR_PULSE;
            ST_WR_PULSE:   if (timer_done) st_d = ST_WR_RECOVER;
            ST_WR_RECOVER: st_d = ST_IDLE;
            default:       st_d = ST_IDLE;
        endcase
        timer_load = (st_d != st_q);
        unique case (st_d)
            ST_READ_WAIT:  timer_val = CNT_W'(RD_CLKS - 1);
            ST_TURNAROUND: timer_val = CNT_W'(TA_CLKS - 1);
            ST_WR_PULSE:   timer_val = CNT_W'(WR_CLKS - 1);
            default:       timer_val = '0;
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        req_ready = 1'b0;
        sample    = 1'b0;
        unique case (st_q)
            ST_IDLE:       req_ready = 1'b1;
            ST_READ_WAIT:  begin mem_ce_n = 1'b0; mem_oe_n = 1'b0; end
            ST_SAMPLE:     begin mem_ce_n = 1'b0; mem_oe_n = 1'b0; sample = 1'b1; end
            ST_TURNAROUND: ;
            ST_WR_SETUP:   begin mem_ce_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_WR_PULSE:   begin mem_ce_n = 1'b0; mem_we_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_WR_RECOVER: begin mem_ce_n = 1'b0; mem_dq_oe = 1'b1; end
            default:       ;
        endcase
    end

    assign accept = req_valid && req_ready;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_done)
    );

    sram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .addr_in (req_addr),
        .data_in (req_wdata),
        .addr_q  (mem_addr),
        .data_q  (mem_dq_o)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample),
        .bus_in  (mem_dq_i),
        .valid_q (rsp_valid),
        .data_q  (rsp_rdata)
    );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n
);
    a_r9_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

    a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    a_r5_we_low_drives: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe && !mem_ce_n));

    a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r10_resp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));

    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

    a_r3_strobes_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!mem_oe_n) && mem_oe_n) |-> mem_ce_n);
endmodule

bind sram_async_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n)
);

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
    localparam int P_NS = 4;
    function automatic int cdiv(input int t);
        int c;
        c = (t + P_NS - 1) / P_NS;
        return (c < 1) ? 1 : c;
    endfunction
    // R8: expected counts from the timing figures
    localparam int E_RD = (cdiv(10) > cdiv(5)) ? cdiv(10) : cdiv(5);
    localparam int E_WR = 2;   // max(ceil(8/4), ceil(6/4), ceil(10/4)-2)
    localparam int E_TA = cdiv(5);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rsp_valid, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
    logic [7:0]  rsp_rdata, mem_dq_o, mem_dq_i;
    logic [14:0] mem_addr;

    int checks = 0, errors = 0;
    bit run = 1'b0;

    always #(P_NS/2) clk = ~clk;

    sram_async_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    // Behavioural memory on the pins
    logic [7:0] mem_m [int];
    logic [7:0] shadow [int];
    function automatic logic [7:0] init_val(input int a);
        return 8'(a * 7 + 3);
    endfunction
    function automatic logic [7:0] mem_rd(input int a);
        if (mem_m.exists(a)) return mem_m[a];
        return init_val(a);
    endfunction
    assign mem_dq_i = (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1)
                      ? mem_rd(int'(mem_addr)) : 8'hEE;
    always @(posedge mem_we_n)
        if (mem_ce_n === 1'b0 && mem_dq_oe === 1'b1) mem_m[int'(mem_addr)] = mem_dq_o;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Reference model: per-cycle expected {ce_n, oe_n, we_n, dq_oe, rsp_valid}
    logic [4:0] exp_q [$];
    logic [14:0] cur_a;
    logic [7:0]  cur_d, exp_rd;

    always @(negedge clk) if (run) begin
        logic [4:0] e;
        bit busy;
        if (exp_q.size() > 0) begin e = exp_q.pop_front(); busy = 1'b1; end
        else begin e = 5'b11100; busy = 1'b0; end
        chk("R3 R5 R8 R9 mem_ce_n", 32'(mem_ce_n), 32'(e[4]));
        chk("R3 R6 R9 mem_oe_n", 32'(mem_oe_n), 32'(e[3]));
        chk("R5 R9 mem_we_n", 32'(mem_we_n), 32'(e[2]));
        chk("R6 R9 mem_dq_oe", 32'(mem_dq_oe), 32'(e[1]));
        chk("R2 req_ready", 32'(req_ready), 32'(!busy));
        chk("R4 R10 rsp_valid", 32'(rsp_valid), 32'(e[0]));
        if (e[0]) chk("R4 rsp_rdata", 32'(rsp_rdata), 32'(exp_rd));
        if (busy && !e[4]) chk("R7 mem_addr", 32'(mem_addr), 32'(cur_a));
        if (e[1]) chk("R7 mem_dq_o", 32'(mem_dq_o), 32'(cur_d));
        if (!busy && req_valid && req_ready) begin
            cur_a = req_addr;
            cur_d = req_wdata;
            if (req_write) begin
                shadow[int'(req_addr)] = req_wdata;
                exp_q.push_back(5'b01110);
                for (int i = 0; i < E_WR; i++) exp_q.push_back(5'b01010);
                exp_q.push_back(5'b01110);
            end else begin
                exp_rd = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)]
                                                       : init_val(int'(req_addr));
                for (int i = 0; i < E_RD + 1; i++) exp_q.push_back(5'b00100);
                exp_q.push_back(5'b11101);
                for (int i = 0; i < E_TA - 1; i++) exp_q.push_back(5'b11100);
            end
        end
    end

    // Issue one request, then scramble the host inputs (R7, R2)
    task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d, input bit hold);
        bit r;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        forever begin
            @(negedge clk); r = req_ready;
            @(posedge clk); #1;
            if (r) break;
        end
        req_addr = ~a; req_wdata = ~d; req_write = !w;
        req_valid = hold;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(200000 * P_NS);
        checks++; errors++;
        $display("FAIL watchdog expired got=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        logic [14:0] pool [8];
        logic [15:0] lfsr;
        pool = '{15'h0000, 15'h7FFF, 15'h0001, 15'h4000, 15'h2AAA, 15'h5555, 15'h0100, 15'h7F00};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1 mem_ce_n", 32'(mem_ce_n), 1);
        chk("R1 mem_oe_n", 32'(mem_oe_n), 1);
        chk("R1 mem_we_n", 32'(mem_we_n), 1);
        chk("R1 mem_dq_oe", 32'(mem_dq_oe), 0);
        chk("R1 req_ready", 32'(req_ready), 1);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        @(posedge clk); #1;
        rst_n = 1'b1; run = 1'b1;
        idle(2);
        issue(1'b1, 15'h0000, 8'hA5, 1'b0);      // R5 R6 write, lowest address
        issue(1'b1, 15'h7FFF, 8'h3C, 1'b0);      // highest address
        idle(3);
        issue(1'b0, 15'h0000, 8'h00, 1'b0);      // R3 R4 read back
        issue(1'b0, 15'h7FFF, 8'h00, 1'b0);
        issue(1'b0, 15'h1234, 8'h00, 1'b0);      // unwritten location
        idle(2);
        issue(1'b1, 15'h0055, 8'h5A, 1'b1);      // R2 valid held while busy
        issue(1'b0, 15'h0055, 8'h00, 1'b1);      // read right after write
        issue(1'b1, 15'h0055, 8'hC3, 1'b1);      // write right after read
        issue(1'b0, 15'h0055, 8'h00, 1'b0);
        lfsr = 16'hACE1;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue(lfsr[0], pool[lfsr[3:1]], lfsr[15:8], lfsr[4]);
        end
        req_valid = 1'b0;
        idle(12);
        run = 1'b0;
        summary();
        $finish;
    end
endmodule